// File: doc/BRIEF.md
# Flash Command and Status Controller

This block is the control logic of a NOR flash device, placed in front of a small uniform-sector byte array. The host sees a plain asynchronous-style memory bus. A write cycle happens when chip enable and write enable are both low on a clock edge. A read cycle happens when chip enable and output enable are both low with write enable high. Fixed sequences of write cycles form commands: byte program, sector erase, entry into a shortened program mode, and suspend/resume of a running operation. The controller runs each program or erase for a set number of clock cycles, counted by a timer, and then commits the result to the array.

While an operation runs, the host polls a status byte on the data bus or watches a ready/busy output. Each sector has a protection input that blocks both program and erase aimed at it. An asynchronous active-low reset abandons any operation and any command in progress. It never clears array contents.

The default size is four sectors of 64 bytes. The address is 8 bits wide: the upper 2 bits select the sector and the lower 6 bits give the offset. The unlock addresses 0x555 and 0x2AA are truncated to the address width, which gives 0x55 and 0xAA at the default size.

Top module: `flash_cmd_ctl`

## Requirements
- R1: After reset, rdyBusyN is 1 and rdData is 0x00. Every array byte reads 0xFF until it is programmed, and a read result appears on rdData one clock after the read cycle.
- R2: Four write cycles start a byte program: 0xAA at 0x55, 0x55 at 0xAA, 0xA0 at 0x55, then the data at the target address. When the program completes, the target byte holds the result.
- R3: A program only clears bits. The stored byte becomes old AND data, so a program with 0xFF leaves the byte unchanged.
- R4: Six write cycles start a sector erase: 0xAA@0x55, 0x55@0xAA, 0x80@0x55, 0xAA@0x55, 0x55@0xAA, then 0x30 at any address in the target sector. Erase sets every byte of that sector to 0xFF and leaves every other sector unchanged.
- R5: The write sequence 0xAA@0x55, 0x55@0xAA, 0x20@0x55 enters bypass mode. In bypass mode a program takes two writes: 0xA0 at any address, then the data at the target. A first write other than 0xA0 is ignored and bypass mode stays active. Only reset leaves bypass mode.
- R6: A write that does not match the expected cycle of a sequence, by data or by unlock address, returns the decoder to read mode. The following writes of the abandoned sequence then start nothing.
- R7: While an operation runs, a read returns a status byte, whatever the address. Bit 7 of the status byte is the complement of bit 7 of the target data (0 for an erase), and bits 5..0 are 0. After completion, reads return the true array data.
- R8: Bit 6 of the status byte is 0 after reset. It inverts after each status read taken while an operation runs, and it holds when no operation runs.
- R9: rdyBusyN is 0 for exactly PROG_CYCLES clocks after the last program write, or ERASE_CYCLES clocks after the erase confirm write, and 1 otherwise.
- R10: The write sequence unlock + 0xB0@0x55 suspends a running erase and sets rdyBusyN to 1. Other sectors can then be read and programmed. A read of the erasing sector returns the status byte without toggling bit 6. A program to the erasing sector is ignored. The write sequence unlock + 0x30@0x55 resumes the erase and completes it.
- R11: The same suspend sequence pauses a running program. Reads of other sectors return array data, a read of the target sector returns the status byte, and every program command is ignored until the resume sequence.
- R12: A program or erase whose target sector has its protMask bit set is ignored. rdyBusyN stays 1 and the array is unchanged.
- R13: Asserting rstN low aborts a running operation without changing the array. It also returns the decoder to read mode and leaves bypass mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W (8) | Byte address; upper bits select the sector |
| wrData | input | 8 | Write-cycle data |
| protMask | input | NUM_SECTORS (4) | Per-sector protection, 1 = protected |
| rdData | output | 8 | Read data or status byte |
| rdyBusyN | output | 1 | 1 = ready, 0 = program or erase running |

## Verification
A read result is due on rdData one clock after the read cycle. The scoreboard queues each expected byte when the read is driven and compares it at the falling edge after the capturing rising edge. rdyBusyN falls one clock after the last write of a command. It stays low for exactly the configured count, so the bench counts falling edges from the return of the write task until ready rises and compares that count with PROG_CYCLES or ERASE_CYCLES. Ignored commands are checked at the falling edge right after their last write, when a started operation would already show busy. The toggle bit is predicted by a bench model that inverts only on status reads taken while an operation runs.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  localparam int NUM_SECTORS  = 4;
  localparam int SECTOR_BYTES = 64;
  localparam int SECT_W       = $clog2(NUM_SECTORS);
  localparam int OFS_W        = $clog2(SECTOR_BYTES);
  localparam int ADDR_W       = SECT_W + OFS_W;
  localparam int MEM_BYTES    = NUM_SECTORS * SECTOR_BYTES;

  localparam logic [7:0] CMD_KEY1    = 8'hAA;
  localparam logic [7:0] CMD_KEY2    = 8'h55;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ESETUP  = 8'h80;
  localparam logic [7:0] CMD_ECONF   = 8'h30;
  localparam logic [7:0] CMD_BYPASS  = 8'h20;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;

  localparam logic [ADDR_W-1:0] KEY_ADDR_A = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] KEY_ADDR_B = ADDR_W'(12'h2AA);

  // strobes from the sequencer to the array datapath
  typedef struct packed {
    logic              commitProg;
    logic              commitErase;
    logic [ADDR_W-1:0] progAddr;
    logic [7:0]        progData;
    logic [SECT_W-1:0] eraseSect;
    logic              statusSel;
    logic              statusBit7;
    logic              toggleRun;
  } ctlStrobe_t;
endpackage

// File: rtl/flash_ctl_fsm.sv
module flash_ctl_fsm
  import flash_ctl_pkg::*;
#(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrStb,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wrData,
  input  logic [NUM_SECTORS-1:0] protMask,
  output logic                   rdyBusyN,
  output ctlStrobe_t             strobe
);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

  typedef enum logic [3:0] {
    C_READ, C_U1, C_U2, C_PDATA, C_E80, C_E1, C_E2, C_BYP
  } cmdState_t;

  typedef enum logic [2:0] {
    O_IDLE, O_PROG, O_PSUSP, O_ERASE, O_ESUSP, O_ESPROG
  } opState_t;

  cmdState_t cmdState, cmdNext, homeState;
  opState_t  opState;
  logic bypass, bypassNext;
  logic progReq, eraseReq, suspReq, resReq;
  logic progOk, eraseOk, commitProg, commitErase, busy;
  logic [CNT_W-1:0] progCnt, eraseCnt;
  logic [ADDR_W-1:0] progAddr;
  logic [7:0] progData;
  logic [SECT_W-1:0] eraseSect, addrSect, progSect;

  assign addrSect = addr[ADDR_W-1 -: SECT_W];
  assign progSect = progAddr[ADDR_W-1 -: SECT_W];

  // command sequence decoder
  always_comb begin
    homeState  = bypass ? C_BYP : C_READ;
    cmdNext    = cmdState;
    bypassNext = bypass;
    progReq    = 1'b0;
    eraseReq   = 1'b0;
    suspReq    = 1'b0;
    resReq     = 1'b0;
    if (wrStb) begin
      unique case (cmdState)
        C_READ: if (addr == KEY_ADDR_A && wrData == CMD_KEY1) cmdNext = C_U1;
        C_U1: cmdNext = (addr == KEY_ADDR_B && wrData == CMD_KEY2) ? C_U2 : homeState;
        C_U2: begin
          cmdNext = homeState;
          if (addr == KEY_ADDR_A) begin
            case (wrData)
              CMD_PROG:    cmdNext = C_PDATA;
              CMD_ESETUP:  cmdNext = C_E80;
              CMD_BYPASS:  begin cmdNext = C_BYP; bypassNext = 1'b1; end
              CMD_SUSPEND: suspReq = 1'b1;
              CMD_RESUME:  resReq = 1'b1;
              default:     cmdNext = homeState;
            endcase
          end
        end
        C_PDATA: begin progReq = 1'b1; cmdNext = homeState; end
        C_E80: cmdNext = (addr == KEY_ADDR_A && wrData == CMD_KEY1) ? C_E1 : homeState;
        C_E1:  cmdNext = (addr == KEY_ADDR_B && wrData == CMD_KEY2) ? C_E2 : homeState;
        C_E2: begin eraseReq = (wrData == CMD_ECONF); cmdNext = homeState; end
        C_BYP: if (wrData == CMD_PROG) cmdNext = C_PDATA;
        default: cmdNext = C_READ;
      endcase
    end
  end

  assign progOk = progReq && !protMask[addrSect] &&
                  (opState == O_IDLE || (opState == O_ESUSP && addrSect != eraseSect));
  assign eraseOk = eraseReq && !protMask[addrSect] && opState == O_IDLE;
  assign commitProg  = (opState == O_PROG || opState == O_ESPROG) && progCnt == CNT_ONE;
  assign commitErase = opState == O_ERASE && eraseCnt == CNT_ONE;
  assign busy = opState inside {O_PROG, O_ERASE, O_ESPROG};
  assign rdyBusyN = !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdState  <= C_READ;
      bypass    <= 1'b0;
      opState   <= O_IDLE;
      progCnt   <= '0;
      eraseCnt  <= '0;
      progAddr  <= '0;
      progData  <= '0;
      eraseSect <= '0;
    end else begin
      cmdState <= cmdNext;
      bypass   <= bypassNext;
      unique case (opState)
        O_IDLE: begin
          if (progOk) begin
            opState <= O_PROG; progCnt <= PROG_LOAD; progAddr <= addr; progData <= wrData;
          end else if (eraseOk) begin
            opState <= O_ERASE; eraseCnt <= ERASE_LOAD; eraseSect <= addrSect;
          end
        end
        O_PROG: begin
          if (commitProg) begin opState <= O_IDLE; progCnt <= '0; end
          else if (suspReq) opState <= O_PSUSP;
          else progCnt <= progCnt - CNT_ONE;
        end
        O_PSUSP: if (resReq) opState <= O_PROG;
        O_ERASE: begin
          if (commitErase) begin opState <= O_IDLE; eraseCnt <= '0; end
          else if (suspReq) opState <= O_ESUSP;
          else eraseCnt <= eraseCnt - CNT_ONE;
        end
        O_ESUSP: begin
          if (resReq) opState <= O_ERASE;
          else if (progOk) begin
            opState <= O_ESPROG; progCnt <= PROG_LOAD; progAddr <= addr; progData <= wrData;
          end
        end
        O_ESPROG: begin
          if (commitProg) begin opState <= O_ESUSP; progCnt <= '0; end
          else progCnt <= progCnt - CNT_ONE;
        end
        default: opState <= O_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.commitProg  = commitProg;
    strobe.commitErase = commitErase;
    strobe.progAddr    = progAddr;
    strobe.progData    = progData;
    strobe.eraseSect   = eraseSect;
    strobe.statusSel   = busy ||
                         (opState == O_PSUSP && addrSect == progSect) ||
                         (opState == O_ESUSP && addrSect == eraseSect);
    strobe.statusBit7  = (opState inside {O_PROG, O_PSUSP, O_ESPROG}) ? ~progData[7] : 1'b0;
    strobe.toggleRun   = busy;
  end

  // R12: nothing is committed into a protected sector
  assert_commit_unprotected_R12: assert property (@(posedge clk) disable iff (!rstN)
    commitProg |-> !protMask[progSect]);
  // R9: busy is only reported while a timer still runs
  assert_busy_has_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdyBusyN |-> (progCnt != '0 || eraseCnt != '0));
  // R9: ready returns right after an erase commit
  assert_ready_after_erase_R9: assert property (@(posedge clk) disable iff (!rstN)
    commitErase |=> rdyBusyN);
  // R10: a suspended erase keeps its remaining time
  assert_erase_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opState == O_ESUSP && $past(opState) == O_ESUSP) |-> $stable(eraseCnt));
endmodule

// File: rtl/flash_ctl_array.sv
module flash_ctl_array
  import flash_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] addr,
  input  ctlStrobe_t        strobe,
  output logic [7:0]        rdData
);
  logic [7:0] mem [MEM_BYTES];
  logic toggle;

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (strobe.commitProg)
      mem[strobe.progAddr] <= mem[strobe.progAddr] & strobe.progData;
    if (strobe.commitErase) begin
      for (int i = 0; i < MEM_BYTES; i++)
        if ((i / SECTOR_BYTES) == int'(strobe.eraseSect)) mem[i] <= 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= 8'h00;
      toggle <= 1'b0;
    end else if (rdStb) begin
      if (strobe.statusSel) begin
        rdData <= {strobe.statusBit7, toggle, 6'b0};
        if (strobe.toggleRun) toggle <= ~toggle;
      end else begin
        rdData <= mem[addr];
      end
    end
  end

  // R8: a status read during an operation inverts the toggle bit
  assert_toggle_flip_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && strobe.statusSel && strobe.toggleRun) |=> (toggle != $past(toggle)));
  // R3: a program never turns a 0 bit into a 1
  assert_prog_clears_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitProg |=>
      ((mem[$past(strobe.progAddr)] & ~$past(mem[strobe.progAddr])) == 8'h00));
endmodule

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl
  import flash_ctl_pkg::*;
#(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ceN,
  input  logic                   weN,
  input  logic                   oeN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wrData,
  input  logic [NUM_SECTORS-1:0] protMask,
  output logic [7:0]             rdData,
  output logic                   rdyBusyN
);
  logic wrStb, rdStb;
  ctlStrobe_t strobe;

  assign wrStb = !ceN && !weN;
  assign rdStb = !ceN && !oeN && weN;

  flash_ctl_fsm #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_fsm (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .addr(addr), .wrData(wrData),
    .protMask(protMask), .rdyBusyN(rdyBusyN), .strobe(strobe)
  );

  flash_ctl_array u_array (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .addr(addr), .strobe(strobe), .rdData(rdData)
  );
endmodule

// File: tb/sim_flash_cmd_ctl.sv
module sim_flash_cmd_ctl;
  import flash_ctl_pkg::*;
  localparam int P = 8;
  localparam int E = 40;
  localparam logic [ADDR_W-1:0] UA = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] UB = ADDR_W'(12'h2AA);

  logic clk = 1'b0;
  logic rstN, ceN, weN, oeN;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wrData;
  logic [NUM_SECTORS-1:0] protMask;
  logic [7:0] rdData;
  logic rdyBusyN;

  flash_cmd_ctl #(.PROG_CYCLES(P), .ERASE_CYCLES(E)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .wrData(wrData), .protMask(protMask), .rdData(rdData), .rdyBusyN(rdyBusyN)
  );

  always #5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic tgl;
  logic [7:0] model [MEM_BYTES];

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];
  logic capFlag = 1'b0;

  always @(posedge clk) capFlag <= (!ceN && !oeN && weN);

  // monitor: compare each captured read with the queued expectation
  always @(negedge clk) begin
    item_t it;
    if (capFlag) begin
      vectors++;
      if (sb.size() == 0) begin
        miscompares++;
        $display("FAIL unexpected read: got %02h expected none", rdData);
      end else begin
        it = sb.pop_front();
        if (rdData !== it.exp) begin
          miscompares++;
          $display("FAIL %s: got %02h expected %02h", it.tag, rdData, it.exp);
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    ceN = 1'b0; weN = 1'b0; addr = a; wrData = d;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, logic [7:0] exp, string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    ceN = 1'b0; oeN = 1'b0; addr = a;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic statusRd(logic [ADDR_W-1:0] a, logic b7, bit running, string tag);
    logic [7:0] e;
    e = {b7, tgl, 6'b0};
    if (running) tgl = ~tgl;
    rd(a, e, tag);
  endtask

  task automatic unlock();
    wr(UA, 8'hAA); wr(UB, 8'h55);
  endtask

  task automatic progCmd(logic [ADDR_W-1:0] a, logic [7:0] d);
    unlock(); wr(UA, 8'hA0); wr(a, d);
  endtask

  task automatic eraseCmd(logic [SECT_W-1:0] s);
    unlock(); wr(UA, 8'h80); unlock(); wr({s, {OFS_W{1'b0}}}, 8'h30);
  endtask

  task automatic suspendCmd(); unlock(); wr(UA, 8'hB0); endtask
  task automatic resumeCmd();  unlock(); wr(UA, 8'h30); endtask

  task automatic waitReady(output int n);
    n = 0;
    while (rdyBusyN !== 1'b1 && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic eraseModel(int s);
    for (int i = 0; i < SECTOR_BYTES; i++) model[s*SECTOR_BYTES + i] = 8'hFF;
  endtask

  initial begin
    int n;
    for (int i = 0; i < MEM_BYTES; i++) model[i] = 8'hFF;
    rstN = 1'b0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    addr = '0; wrData = '0; protMask = '0; tgl = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ready after reset", rdyBusyN, 1);
    check("R1 rdData after reset", rdData, 0);
    rd(8'h00, 8'hFF, "R1 erased byte");
    rd(8'hC3, 8'hFF, "R1 erased byte");

    // R2 / R9 four-cycle program and busy length
    progCmd(8'h10, 8'h5A);
    check("R9 busy after program", rdyBusyN, 0);
    waitReady(n);
    check("R9 program busy cycles", n, P);
    model[8'h10] &= 8'h5A;
    rd(8'h10, model[8'h10], "R2 programmed byte");

    // R3 only clears bits
    progCmd(8'h10, 8'hF0); waitReady(n);
    model[8'h10] &= 8'hF0;
    rd(8'h10, model[8'h10], "R3 AND result");
    progCmd(8'h10, 8'hFF); waitReady(n);
    rd(8'h10, 8'h50, "R3 no bit set");

    // R7 / R8 status polling during program
    progCmd(8'h30, 8'h5A);
    statusRd(8'h30, 1'b1, 1'b1, "R7 R8 status first");
    statusRd(8'h00, 1'b1, 1'b1, "R7 R8 status any addr");
    waitReady(n);
    model[8'h30] &= 8'h5A;
    rd(8'h30, 8'h5A, "R7 true data after done");
    rd(8'h30, 8'h5A, "R8 no toggle after done");

    // R4 sector erase
    progCmd(8'h45, 8'h12); waitReady(n); model[8'h45] &= 8'h12;
    progCmd(8'h48, 8'h77); waitReady(n); model[8'h48] &= 8'h77;
    eraseCmd(2'd0);
    statusRd(8'h05, 1'b0, 1'b1, "R7 erase status");
    waitReady(n);
    check("R9 erase busy cycles", n + 1, E);
    eraseModel(0);
    rd(8'h10, 8'hFF, "R4 erased byte");
    rd(8'h30, 8'hFF, "R4 erased byte");
    rd(8'h45, model[8'h45], "R4 other sector kept");

    // R6 wrong cycles
    wr(UA, 8'hAA); wr(UB, 8'h54); wr(UA, 8'hA0); wr(8'h21, 8'h00);
    check("R6 wrong data no busy", rdyBusyN, 1);
    rd(8'h21, 8'hFF, "R6 byte unchanged");
    wr(UA, 8'hAA); wr(UA, 8'h55); wr(UA, 8'hA0); wr(8'h22, 8'h00);
    check("R6 wrong addr no busy", rdyBusyN, 1);
    rd(8'h22, 8'hFF, "R6 byte unchanged");

    // R12 protection
    progCmd(8'h91, 8'h66); waitReady(n); model[8'h91] &= 8'h66;
    protMask = 4'b0100;
    progCmd(8'h90, 8'h00);
    check("R12 protected program", rdyBusyN, 1);
    eraseCmd(2'd2);
    check("R12 protected erase", rdyBusyN, 1);
    rd(8'h90, 8'hFF, "R12 program ignored");
    rd(8'h91, model[8'h91], "R12 erase ignored");
    protMask = '0;

    // R10 erase suspend
    eraseCmd(2'd1);
    repeat (3) @(negedge clk);
    suspendCmd();
    check("R10 ready while suspended", rdyBusyN, 1);
    statusRd(8'h48, 1'b0, 1'b0, "R10 suspended sector status");
    rd(8'hC0, 8'hFF, "R10 other sector read");
    progCmd(8'hC0, 8'h3C);
    check("R10 program in suspend busy", rdyBusyN, 0);
    waitReady(n);
    check("R10 program in suspend cycles", n, P);
    model[8'hC0] &= 8'h3C;
    rd(8'hC0, 8'h3C, "R10 program in suspend");
    progCmd(8'h41, 8'h00);
    check("R10 program to erasing sector ignored", rdyBusyN, 1);
    resumeCmd();
    check("R10 busy after resume", rdyBusyN, 0);
    waitReady(n);
    eraseModel(1);
    rd(8'h48, 8'hFF, "R10 erase completed");
    rd(8'hC0, 8'h3C, "R4 other sector kept");

    // R11 program suspend
    progCmd(8'h20, 8'h0F);
    suspendCmd();
    check("R11 ready while suspended", rdyBusyN, 1);
    rd(8'hC0, 8'h3C, "R11 other sector read");
    statusRd(8'h20, 1'b1, 1'b0, "R11 suspended sector status");
    progCmd(8'hC1, 8'h00);
    check("R11 program ignored", rdyBusyN, 1);
    rd(8'hC1, 8'hFF, "R11 program ignored");
    resumeCmd();
    check("R11 busy after resume", rdyBusyN, 0);
    waitReady(n);
    model[8'h20] &= 8'h0F;
    rd(8'h20, 8'h0F, "R11 program completed");

    // R5 unlock bypass
    unlock(); wr(UA, 8'h20);
    wr(8'h00, 8'hA0); wr(8'hE0, 8'hA5);
    waitReady(n);
    check("R5 bypass program cycles", n, P);
    rd(8'hE0, 8'hA5, "R5 bypass program");
    wr(8'h00, 8'h12);
    check("R5 non-A0 ignored", rdyBusyN, 1);
    wr(8'h00, 8'hA0); wr(8'hE2, 8'h11);
    waitReady(n);
    check("R5 still bypass", n, P);
    rd(8'hE2, 8'h11, "R5 second bypass program");

    // R13 reset aborts
    wr(8'h00, 8'hA0); wr(8'hF0, 8'h00);
    check("R13 busy before reset", rdyBusyN, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1; tgl = 1'b0;
    check("R13 ready after reset", rdyBusyN, 1);
    check("R13 rdData after reset", rdData, 0);
    rd(8'hF0, 8'hFF, "R13 aborted program");
    wr(8'h00, 8'hA0); wr(8'hF1, 8'h00);
    check("R13 bypass left", rdyBusyN, 1);
    rd(8'hF1, 8'hFF, "R13 bypass left");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      miscompares++;
      $display("FAIL R1 pending reads: got %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R9: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule